// File: doc/BRIEF.md
# ADC Conversion Start and Trigger Controller

This block decides when a successive-approximation conversion engine starts working. It has three ways to start a conversion. Software can raise a start strobe. An auto-trigger source, picked by a select code, can start one on a rising edge. A synchronization pulse from a PWM unit can also start one, and that path can be limited to a single shot. For each start the block sends the engine a one-cycle start pulse and the channel that was latched at that moment. It holds a busy status, which software reads as the start bit, until the engine reports that it is done. A start from a trigger also sends a one-cycle reset to the conversion clock prescaler.

Trigger sources are sampled on the block clock. An edge counts only when the present sample of the selected source is high and the previous sample was low. Edges that come while a conversion is running are dropped. A source that is still high when the conversion ends does not start a new one, so a source that works as a flag has to be cleared before it can fire again. The PWM sync path has no such flag and starts a conversion on every pulse, unless single-shot mode is on. In single-shot mode the path stays blocked after one conversion until the result high byte has been read. The reference selection is held in its own register, and writes to it take effect whether the converter is enabled or not.

Top module: `adc_start_ctrl`

## Requirements
- R1: A software start strobe (`sw_start_i`) seen while idle and enabled raises `busy_o` and gives a one-cycle `start_o` one clock later. `busy_o` stays high until `done_i` is seen, and then drops one clock later.
- R2: `chan_o` loads `chan_sel_i` on the clock that starts a conversion. It keeps that value for the whole conversion, whatever `chan_sel_i` does.
- R3: With `auto_en_i` high, a rising edge on source `trig_src_i[k]` with `tsel_i == k` starts a conversion and raises `presc_rst_o` together with `start_o`. This happens two clocks after the source rises. With `auto_en_i` low, edges have no effect.
- R4: A trigger edge that arrives while `busy_o` is high is ignored.
- R5: A trigger that is still high when the conversion completes starts nothing. A new conversion needs the source to go low and then rise again.
- R6: With `tsel_i == NUM_SRC` (the sync code), every one-cycle pulse on `pwm_sync_i` seen while idle starts a conversion. The start comes two clocks after the pulse and carries `presc_rst_o`.
- R7: With `single_shot_i` high, once a sync pulse has started a conversion, later sync pulses are ignored until a `hi_rd_i` strobe is seen.
- R8: While `en_i` is low, no conversion starts. Dropping `en_i` during a conversion clears `busy_o` one clock later.
- R9: `ref_we_i` loads `ref_sel_i` into `ref_o` one clock later, whatever the value of `en_i`.
- R10: A software strobe and a trigger edge in the same cycle start exactly one conversion: one `start_o` pulse, followed by no second start after `done_i`.
- R11: Edges on sources other than the one selected by `tsel_i` start nothing. Codes above `NUM_SRC` select no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Converter enable |
| sw_start_i | input | 1 | Software start strobe |
| auto_en_i | input | 1 | Auto-trigger enable |
| tsel_i | input | SEL_W | Trigger select: 0..NUM_SRC-1 picks a source, NUM_SRC picks PWM sync, higher codes pick nothing |
| trig_src_i | input | NUM_SRC | Auto-trigger source levels |
| pwm_sync_i | input | 1 | PWM synchronization pulse |
| single_shot_i | input | 1 | Single-shot enable for the sync path |
| chan_sel_i | input | CHAN_W | Requested input channel |
| done_i | input | 1 | Conversion engine finished |
| hi_rd_i | input | 1 | Result high byte read strobe |
| ref_we_i | input | 1 | Reference selection write strobe |
| ref_sel_i | input | REF_W | Reference selection data |
| busy_o | output | 1 | Conversion running (start bit status) |
| start_o | output | 1 | One-cycle start pulse to the engine |
| presc_rst_o | output | 1 | Prescaler reset pulse on triggered starts |
| chan_o | output | CHAN_W | Channel latched for the running conversion |
| ref_o | output | REF_W | Held reference selection |

## Verification
The bench uses NUM_SRC = 4, CHAN_W = 4 and REF_W = 2, so `tsel_i` is three bits wide. With these values one run can reach every kind of select code: a real source (1), a source that is present but not selected (3), the sync code (4) and codes that select nothing. Four channel bits allow distinct channel values before and during a conversion, which makes a latch that follows its input visible. The directed tasks place trigger edges both inside and outside conversions, and they line a software strobe up with an edge in the same cycle.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_st_e;

  typedef struct packed {
    logic sw_hit;
    logic rise_hit;
    logic sync_hit;
  } start_req_t;

endpackage

// File: rtl/adc_trig_rise.sv
module adc_trig_rise #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               rise_o
);

  logic [NUM_SRC-1:0] src_q, src_d;
  logic [NUM_SRC-1:0] hit;
  logic               picked;
  logic               picked_q, picked_d;

  // one synchronous sample stage for all sources
  always_comb src_d = src_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
    assign hit[g] = src_q[g] & (sel_i == SEL_W'(g));
  end

  always_comb begin
    picked   = |hit;
    picked_d = picked;
    rise_o   = picked & ~picked_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      picked_q <= 1'b0;
    end else begin
      src_q    <= src_d;
      picked_q <= picked_d;
    end
  end

  // R3: a detected rise lasts one cycle while the selection is steady
  assert_rise_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> (!rise_o || !$stable(sel_i)));

endmodule

// File: rtl/adc_sync_gate.sv
module adc_sync_gate #(
  parameter int SEL_W     = 3,
  parameter int SYNC_CODE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             single_i,
  input  logic             hi_rd_i,
  input  logic             taken_i,
  output logic             req_o
);

  logic sync_q, sync_d;
  logic blocked_q, blocked_d;
  logic chosen;

  always_comb begin
    sync_d = sync_i;
    chosen = (sel_i == SEL_W'(SYNC_CODE));
    if (!single_i)     blocked_d = 1'b0;
    else if (taken_i)  blocked_d = 1'b1;
    else if (hi_rd_i)  blocked_d = 1'b0;
    else               blocked_d = blocked_q;
    req_o = sync_q & chosen & ~blocked_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 1'b0;
      blocked_q <= 1'b0;
    end else begin
      sync_q    <= sync_d;
      blocked_q <= blocked_d;
    end
  end

  // R7: a blocked sync path never requests a start
  assert_blocked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_q |-> !req_o);

  // R7: a taken single-shot sync start blocks the path on the next cycle
  assert_block_after_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_i && single_i) |=> !req_o);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_start_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sw_start_i,
  input  logic              auto_en_i,
  input  logic              rise_i,
  input  logic              sync_req_i,
  input  logic              done_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              presc_rst_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              sync_taken_o
);

  conv_st_e           st_q, st_d;
  start_req_t         req;
  logic               accept;
  logic               start_q, start_d;
  logic               presc_q, presc_d;
  logic [CHAN_W-1:0]  chan_q;
  logic               chan_en;

  always_comb begin
    req.sw_hit   = sw_start_i;
    req.rise_hit = auto_en_i & rise_i;
    req.sync_hit = auto_en_i & sync_req_i;
    accept  = (st_q == ST_IDLE) & en_i &
              (req.sw_hit | req.rise_hit | req.sync_hit);
    chan_en = accept;
    start_d = accept;
    presc_d = accept & (req.rise_hit | req.sync_hit);
    sync_taken_o = accept & req.sync_hit;
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_CONV;
      ST_CONV: if (!en_i || done_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      presc_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      presc_q <= presc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
    end else if (chan_en) begin
      chan_q <= chan_i;
    end
  end

  always_comb begin
    busy_o      = (st_q == ST_CONV);
    start_o     = start_q;
    presc_rst_o = presc_q;
    chan_o      = chan_q;
  end

  // R1: the start pulse is always seen together with busy
  assert_start_with_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);

  // R1: completion releases busy one clock later
  assert_done_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i) |=> !busy_o);

  // R2: channel held while a conversion runs
  assert_chan_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(chan_o));

  // R4: no new start is issued out of a running conversion
  assert_no_start_when_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !start_o);

  // R8: disable stops the converter
  assert_disable_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);

  // R10: a start pulse never lasts two cycles
  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
  parameter int NUM_SRC = 4,
  parameter int CHAN_W  = 4,
  parameter int REF_W   = 2,
  localparam int SEL_W  = $clog2(NUM_SRC + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sw_start_i,
  input  logic               auto_en_i,
  input  logic [SEL_W-1:0]   tsel_i,
  input  logic [NUM_SRC-1:0] trig_src_i,
  input  logic               pwm_sync_i,
  input  logic               single_shot_i,
  input  logic [CHAN_W-1:0]  chan_sel_i,
  input  logic               done_i,
  input  logic               hi_rd_i,
  input  logic               ref_we_i,
  input  logic [REF_W-1:0]   ref_sel_i,
  output logic               busy_o,
  output logic               start_o,
  output logic               presc_rst_o,
  output logic [CHAN_W-1:0]  chan_o,
  output logic [REF_W-1:0]   ref_o
);

  localparam int SYNC_CODE = NUM_SRC;

  logic             rst_meta_q, rst_sync_q;
  logic             rise;
  logic             sync_req;
  logic             sync_taken;
  logic [REF_W-1:0] ref_q;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  adc_trig_rise #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W)
  ) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .src_i  (trig_src_i),
    .sel_i  (tsel_i),
    .rise_o (rise)
  );

  adc_sync_gate #(
    .SEL_W     (SEL_W),
    .SYNC_CODE (SYNC_CODE)
  ) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .sync_i   (pwm_sync_i),
    .sel_i    (tsel_i),
    .single_i (single_shot_i),
    .hi_rd_i  (hi_rd_i),
    .taken_i  (sync_taken),
    .req_o    (sync_req)
  );

  adc_conv_seq #(
    .CHAN_W (CHAN_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_q),
    .en_i         (en_i),
    .sw_start_i   (sw_start_i),
    .auto_en_i    (auto_en_i),
    .rise_i       (rise),
    .sync_req_i   (sync_req),
    .done_i       (done_i),
    .chan_i       (chan_sel_i),
    .busy_o       (busy_o),
    .start_o      (start_o),
    .presc_rst_o  (presc_rst_o),
    .chan_o       (chan_o),
    .sync_taken_o (sync_taken)
  );

  // reference selection: written whatever the enable
  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      ref_q <= '0;
    end else if (ref_we_i) begin
      ref_q <= ref_sel_i;
    end
  end

  always_comb ref_o = ref_q;

  // R9: a write lands whatever the enable
  assert_ref_write_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    ref_we_i |=> (ref_o == $past(ref_sel_i)));

  // R6: prescaler reset only accompanies a start
  assert_presc_with_start_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    presc_rst_o |-> start_o);

endmodule

// File: tb/sim_adc_start_ctrl.sv
module sim_adc_start_ctrl;

  localparam int NUM_SRC = 4;
  localparam int CHAN_W  = 4;
  localparam int REF_W   = 2;
  localparam int SEL_W   = $clog2(NUM_SRC + 2);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               en, sw_start, auto_en, pwm_sync, single_shot, done, hi_rd, ref_we;
  logic [SEL_W-1:0]   tsel;
  logic [NUM_SRC-1:0] trig;
  logic [CHAN_W-1:0]  chan_sel;
  logic [REF_W-1:0]   ref_sel;
  logic               busy, start, presc;
  logic [CHAN_W-1:0]  chan;
  logic [REF_W-1:0]   refo;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  adc_start_ctrl #(.NUM_SRC(NUM_SRC), .CHAN_W(CHAN_W), .REF_W(REF_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sw_start_i(sw_start),
    .auto_en_i(auto_en), .tsel_i(tsel), .trig_src_i(trig),
    .pwm_sync_i(pwm_sync), .single_shot_i(single_shot), .chan_sel_i(chan_sel),
    .done_i(done), .hi_rd_i(hi_rd), .ref_we_i(ref_we), .ref_sel_i(ref_sel),
    .busy_o(busy), .start_o(start), .presc_rst_o(presc), .chan_o(chan), .ref_o(refo)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_conv();
    done = 1'b1; step(); done = 1'b0;
    chk("R1", "busy after done", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset start", int'(start), 0);
    chk("R2", "reset chan", int'(chan), 0);
    chk("R9", "reset ref", int'(refo), 0);
  endtask

  task automatic t_sw_start();
    chan_sel = 4'd5; sw_start = 1'b1; step(); sw_start = 1'b0;
    chk("R1", "sw busy", int'(busy), 1);
    chk("R1", "sw start pulse", int'(start), 1);
    chk("R1", "sw no presc", int'(presc), 0);
    chk("R2", "chan latched", int'(chan), 5);
    chan_sel = 4'd9; step();
    chk("R1", "start one cycle", int'(start), 0);
    chk("R2", "chan held", int'(chan), 5);
    step(2);
    chk("R1", "busy held", int'(busy), 1);
    finish_conv();
    step();
    chk("R1", "stays idle", int'(busy), 0);
  endtask

  task automatic t_auto_rise();
    tsel = 3'd1; auto_en = 1'b1; chan_sel = 4'd3;
    trig[1] = 1'b1; step();
    chk("R3", "one sample stage", int'(busy), 0);
    step();
    chk("R3", "edge busy", int'(busy), 1);
    chk("R3", "edge start", int'(start), 1);
    chk("R3", "edge presc", int'(presc), 1);
    finish_conv();
    trig[1] = 1'b0; step(2);
  endtask

  task automatic t_busy_edge();
    sw_start = 1'b1; step(); sw_start = 1'b0;
    chk("R4", "sw busy", int'(busy), 1);
    trig[1] = 1'b1; step(3);
    chk("R4", "edge during conv", int'(start), 0);
    finish_conv();
    step(3);
    chk("R5", "held high no restart", int'(busy), 0);
    trig[1] = 1'b0; step(2);
    trig[1] = 1'b1; step(2);
    chk("R5", "fresh edge starts", int'(start), 1);
    finish_conv();
    trig[1] = 1'b0; step(2);
  endtask

  task automatic t_auto_off();
    auto_en = 1'b0; trig[1] = 1'b1; step(3);
    chk("R3", "auto disabled", int'(busy), 0);
    trig[1] = 1'b0; auto_en = 1'b1; step(2);
  endtask

  task automatic t_unselected();
    tsel = 3'd1; trig[3] = 1'b1; step(3);
    chk("R11", "other source", int'(busy), 0);
    trig[3] = 1'b0; step(2);
    tsel = 3'd5; trig = '1; step(3);
    chk("R11", "none code", int'(busy), 0);
    trig = '0; step(2);
  endtask

  task automatic t_sync();
    tsel = 3'(NUM_SRC); single_shot = 1'b0;
    for (int i = 0; i < 2; i++) begin
      pwm_sync = 1'b1; step(); pwm_sync = 1'b0;
      chk("R6", "sync latency", int'(busy), 0);
      step();
      chk("R6", "sync start", int'(start), 1);
      chk("R6", "sync presc", int'(presc), 1);
      finish_conv();
      step();
    end
  endtask

  task automatic t_single();
    tsel = 3'(NUM_SRC); single_shot = 1'b1;
    pwm_sync = 1'b1; step(); pwm_sync = 1'b0; step();
    chk("R7", "first shot", int'(start), 1);
    finish_conv();
    pwm_sync = 1'b1; step(); pwm_sync = 1'b0; step(2);
    chk("R7", "blocked shot", int'(busy), 0);
    hi_rd = 1'b1; step(); hi_rd = 1'b0;
    pwm_sync = 1'b1; step(); pwm_sync = 1'b0; step();
    chk("R7", "after high read", int'(start), 1);
    finish_conv();
    single_shot = 1'b0; step();
  endtask

  task automatic t_enable();
    en = 1'b0; sw_start = 1'b1; step(); sw_start = 1'b0; step();
    chk("R8", "disabled start", int'(busy), 0);
    en = 1'b1; sw_start = 1'b1; step(); sw_start = 1'b0;
    chk("R8", "enabled start", int'(busy), 1);
    en = 1'b0; step();
    chk("R8", "abort", int'(busy), 0);
    en = 1'b1; step();
  endtask

  task automatic t_ref();
    en = 1'b0; ref_sel = 2'd2; ref_we = 1'b1; step(); ref_we = 1'b0;
    chk("R9", "ref write disabled", int'(refo), 2);
    ref_sel = 2'd1; step();
    chk("R9", "ref held", int'(refo), 2);
    en = 1'b1; ref_sel = 2'd3; ref_we = 1'b1; step(); ref_we = 1'b0;
    chk("R9", "ref write enabled", int'(refo), 3);
  endtask

  task automatic t_simul();
    tsel = 3'd1; auto_en = 1'b1;
    trig[1] = 1'b1; step();
    sw_start = 1'b1; step(); sw_start = 1'b0;
    chk("R10", "joint start", int'(start), 1);
    chk("R10", "joint presc", int'(presc), 1);
    step();
    chk("R10", "no second pulse", int'(start), 0);
    finish_conv();
    step(2);
    chk("R10", "no second conv", int'(busy), 0);
    trig[1] = 1'b0; step(2);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; sw_start = 1'b0; auto_en = 1'b0; pwm_sync = 1'b0;
    single_shot = 1'b0; done = 1'b0; hi_rd = 1'b0; ref_we = 1'b0;
    tsel = '0; trig = '0; chan_sel = '0; ref_sel = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    en = 1'b1; step();
    t_sw_start();
    t_auto_rise();
    t_busy_edge();
    t_auto_off();
    t_unselected();
    t_sync();
    t_single();
    t_enable();
    t_ref();
    t_simul();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule